// File: doc/BRIEF.md
# SPI Register Access Frame Controller

This block is the serial slave front end of a small control register bank. A host drives 16-bit frames over a four-wire serial link: clock, active-low chip select, data in and data out, in SPI mode 0 with the most significant bit first. The first four bits of each frame form a header. Two of them pick a register bank, one picks which register of that bank is returned on the data-out line, and one marks the frame as read-only. The low byte of the frame is the value written to the bank's control register when a write is allowed.

All link pins are brought into the system clock domain through synchronizers and edge detectors, so the serial clock must run well below the system clock. A four-state machine frames each access. `ST_IDLE` leaves on a low chip select (transition "open"), which also snapshots every readable register. `ST_SHIFT` samples data on rising serial-clock edges and drives the response on falling edges. It leaves on a high chip select either to `ST_COMMIT` when exactly 16 rising edges were counted (transition "accept") or to `ST_REJECT` otherwise (transition "reject"). Both of those states return to `ST_IDLE` after one cycle (transition "close"). A rejected frame never writes anything. If the failure-interrupt enable bit is set, the rejection raises a one-cycle failure pulse; if the bit is clear, the frame is dropped with no trace.

The response word carries a zero upper nibble and the selected register value zero-extended in the lower 12 bits. Because every readable register is captured when the frame opens, a write made by a frame never alters the word that same frame returns.

Top module: `spi_reg_access`

## Requirements
- R1: After reset the mode register reads 0x80, the interrupt-enable register reads 0x00, the data-out line is 0, and no strobe or failure pulse is active.
- R2: A frame is 16 bits, most significant bit first. Bits 15:14 are the bank, bit 13 is the read select, bit 12 is read-only, and bits 7:0 are the write value. Bits 11:8 have no effect on any register.
- R3: The response word is 16 bits, and bits 15:12 are always 0. Bits 11:0 carry the selected 8-bit value zero-extended: bank 00 with select 1 gives the diagnosis input, bank 00 with select 0 gives the mode register, bank 01 with select 1 gives the interrupt input, bank 01 with select 0 gives the interrupt-enable register, and banks 10 and 11 give 0.
- R4: A frame with the read-only bit set to 1 changes no register and raises no write strobe.
- R5: A 16-bit frame with read-only 0 writes the mode register for bank 00 or the interrupt-enable register for bank 01. It pulses the matching strobe for one cycle, with the stored value on the write-data output. Banks 10 and 11 write nothing.
- R6: Bit 7 of the mode register always reads 1, and bit 7 of the interrupt-enable register always reads 0, whatever is written.
- R7: A frame with any count of rising clock edges other than 16, including zero, changes no register and raises no write strobe.
- R8: A frame rejected for its length raises the failure pulse when interrupt-enable bit 0 is 1, and raises nothing when that bit is 0.
- R9: The response reflects register and input values as they were when chip select fell, including for a frame that writes the register it reads back.
- R10: The data-out line is 0 whenever chip select is high and the block is idle.
- R11: Every write strobe and every failure pulse lasts exactly one cycle, and at most one of them is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial response to the host |
| diag_in | input | 8 | Diagnosis status value, read-only over the link |
| irq_in | input | 8 | Interrupt status value, read-only over the link |
| mode_wr | output | 1 | One-cycle strobe when the mode register is written |
| ie_wr | output | 1 | One-cycle strobe when the interrupt-enable register is written |
| wr_data | output | 8 | Value stored by the latest write |
| mode_value | output | 8 | Current mode register |
| ie_value | output | 8 | Current interrupt-enable register |
| spi_fail | output | 1 | One-cycle pulse for a rejected frame when enabled |

## Verification
The embedded properties watch the cycle-level rules on every clock. Registers hold their value in any cycle without a strobe. A strobe carries the stored value. A commit only follows a shift phase that counted exactly 16 edges. Pulses are single-cycle and mutually exclusive. The data-out line is quiet while idle. The bench's scenarios are needed to show which register each header returns, the zero upper nibble, the reserved-bit constants, and the snapshot timing when an input changes in mid-frame or a frame reads back the register it writes. They also show that the failure pulse depends on the enable bit across a sweep of frame lengths from 0 to 20.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_REJECT = 2'd3
    } acc_state_e;

    localparam logic [1:0] BANK_DIAG_MODE = 2'b00;
    localparam logic [1:0] BANK_INT       = 2'b01;

    typedef struct packed {
        logic [1:0] bank;
        logic       rsel;
        logic       ronly;
    } acc_hdr_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
            end
        end

        assign lvl_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regacc_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic              spif_en_i,
    input  logic [DATA_W-1:0] snap_diag_i,
    input  logic [DATA_W-1:0] snap_mode_i,
    input  logic [DATA_W-1:0] snap_irq_i,
    input  logic [DATA_W-1:0] snap_ie_i,
    output logic              snap_o,
    output logic              commit_o,
    output acc_hdr_t          commit_hdr_o,
    output logic [DATA_W-1:0] commit_data_o,
    output logic              fail_o,
    output logic              miso_o
);

    localparam int CNT_W   = $clog2(FRAME_BITS + 1) + 1;
    localparam int HDR_W   = 4;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    acc_state_e            state_q, state_d;
    logic                  sclk_q;
    logic                  sclk_rise, sclk_fall;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [1:0]            hdr_bank_q;
    logic                  hdr_rsel_q;
    logic                  len_ok;
    logic [DATA_W-1:0]     pay_sel;
    logic [FRAME_BITS-1:0] resp_word;
    logic                  next_bit;

    assign sclk_rise = sclk_i & ~sclk_q;
    assign sclk_fall = ~sclk_i & sclk_q;
    assign len_ok    = (cnt_q == CNT_FULL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!csn_i) state_d = ST_SHIFT;
            ST_SHIFT:  if (csn_i)  state_d = len_ok ? ST_COMMIT : ST_REJECT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift datapath: edge counter, receive register, captured header
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q     <= 1'b0;
            cnt_q      <= '0;
            shreg_q    <= '0;
            hdr_bank_q <= '0;
            hdr_rsel_q <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            if (state_q == ST_IDLE && !csn_i) begin
                cnt_q      <= '0;
                shreg_q    <= '0;
                hdr_bank_q <= '0;
                hdr_rsel_q <= 1'b0;
            end else if (state_q == ST_SHIFT && !csn_i && sclk_rise) begin
                shreg_q <= {shreg_q[FRAME_BITS-2:0], mosi_i};
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(0)) hdr_bank_q[1] <= mosi_i;
                if (cnt_q == CNT_W'(1)) hdr_bank_q[0] <= mosi_i;
                if (cnt_q == CNT_W'(2)) hdr_rsel_q    <= mosi_i;
            end
        end
    end

    // response selection from the snapshot, chosen by the received header
    always_comb begin
        case ({hdr_bank_q, hdr_rsel_q})
            {BANK_DIAG_MODE, 1'b1}: pay_sel = snap_diag_i;
            {BANK_DIAG_MODE, 1'b0}: pay_sel = snap_mode_i;
            {BANK_INT, 1'b1}:       pay_sel = snap_irq_i;
            {BANK_INT, 1'b0}:       pay_sel = snap_ie_i;
            default:                pay_sel = '0;
        endcase
        resp_word = FRAME_BITS'(pay_sel);
    end

    always_comb begin
        next_bit = 1'b0;
        for (int b = 0; b < FRAME_BITS; b++) begin
            if (cnt_q == CNT_W'(FRAME_BITS - 1 - b)) next_bit = resp_word[b];
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_o        <= 1'b0;
            commit_o      <= 1'b0;
            commit_hdr_o  <= '0;
            commit_data_o <= '0;
            fail_o        <= 1'b0;
            miso_o        <= 1'b0;
        end else begin
            snap_o   <= 1'b0;
            commit_o <= 1'b0;
            fail_o   <= 1'b0;
            if (state_q == ST_IDLE && state_d == ST_SHIFT) begin
                snap_o <= 1'b1;
            end
            if (state_d != ST_SHIFT) begin
                miso_o <= 1'b0;
            end else if (sclk_fall) begin
                miso_o <= next_bit;
            end
            if (state_q == ST_SHIFT && state_d == ST_COMMIT) begin
                commit_o      <= 1'b1;
                commit_hdr_o  <= acc_hdr_t'(shreg_q[FRAME_BITS-1 -: HDR_W]);
                commit_data_o <= shreg_q[DATA_W-1:0];
            end
            if (state_q == ST_SHIFT && state_d == ST_REJECT) begin
                fail_o <= spif_en_i;
            end
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !miso_o);

    assert_fail_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);

    assert_commit_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(state_q) == ST_SHIFT && $past(cnt_q) == CNT_FULL));

    assert_fail_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> ($past(cnt_q) != CNT_FULL));

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_regacc_pkg::*;
#(
    parameter int                DATA_W        = 8,
    parameter logic [DATA_W-1:0] MODE_RST      = 8'h80,
    parameter logic [DATA_W-1:0] MODE_RSV_MASK = 8'h80,
    parameter logic [DATA_W-1:0] MODE_RSV_VAL  = 8'h80,
    parameter logic [DATA_W-1:0] IE_RST        = 8'h00,
    parameter logic [DATA_W-1:0] IE_RSV_MASK   = 8'h80,
    parameter logic [DATA_W-1:0] IE_RSV_VAL    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snap_i,
    input  logic              commit_i,
    input  acc_hdr_t          commit_hdr_i,
    input  logic [DATA_W-1:0] commit_data_i,
    input  logic [DATA_W-1:0] diag_i,
    input  logic [DATA_W-1:0] irq_i,
    output logic [DATA_W-1:0] mode_q_o,
    output logic [DATA_W-1:0] ie_q_o,
    output logic              mode_wr_o,
    output logic              ie_wr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] snap_diag_o,
    output logic [DATA_W-1:0] snap_mode_o,
    output logic [DATA_W-1:0] snap_irq_o,
    output logic [DATA_W-1:0] snap_ie_o
);

    logic [DATA_W-1:0] mode_merged, ie_merged;
    logic              do_write;

    assign mode_merged = (commit_data_i & ~MODE_RSV_MASK) | (MODE_RSV_VAL & MODE_RSV_MASK);
    assign ie_merged   = (commit_data_i & ~IE_RSV_MASK)   | (IE_RSV_VAL & IE_RSV_MASK);
    assign do_write    = commit_i && !commit_hdr_i.ronly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q_o  <= MODE_RST;
            ie_q_o    <= IE_RST;
            mode_wr_o <= 1'b0;
            ie_wr_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            mode_wr_o <= 1'b0;
            ie_wr_o   <= 1'b0;
            if (do_write && commit_hdr_i.bank == BANK_DIAG_MODE) begin
                mode_q_o  <= mode_merged;
                mode_wr_o <= 1'b1;
                wr_data_o <= mode_merged;
            end else if (do_write && commit_hdr_i.bank == BANK_INT) begin
                ie_q_o    <= ie_merged;
                ie_wr_o   <= 1'b1;
                wr_data_o <= ie_merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_diag_o <= '0;
            snap_mode_o <= '0;
            snap_irq_o  <= '0;
            snap_ie_o   <= '0;
        end else if (snap_i) begin
            snap_diag_o <= diag_i;
            snap_mode_o <= mode_q_o;
            snap_irq_o  <= irq_i;
            snap_ie_o   <= ie_q_o;
        end
    end

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_o |-> $stable(mode_q_o));

    assert_ie_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_wr_o |-> $stable(ie_q_o));

    assert_mode_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_o |-> (wr_data_o == mode_q_o));

    assert_ie_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ie_wr_o |-> (wr_data_o == ie_q_o));

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_o || ie_wr_o) |=> !(mode_wr_o || ie_wr_o));

endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
    import spi_regacc_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SPIF_IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DATA_W-1:0] diag_in,
    input  logic [DATA_W-1:0] irq_in,
    output logic              mode_wr,
    output logic              ie_wr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mode_value,
    output logic [DATA_W-1:0] ie_value,
    output logic              spi_fail
);

    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b010;  // {mosi, csn, sclk}

    logic [PIN_N-1:0]  pins_s;
    logic              snap, commit;
    acc_hdr_t          commit_hdr;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] snap_diag, snap_mode, snap_irq, snap_ie;

    spi_pin_sync #(
        .N       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({spi_mosi, spi_csn, spi_sclk}),
        .lvl_o (pins_s)
    );

    spi_frame_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_W     (DATA_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk_i        (pins_s[0]),
        .csn_i         (pins_s[1]),
        .mosi_i        (pins_s[2]),
        .spif_en_i     (ie_value[SPIF_IDX]),
        .snap_diag_i   (snap_diag),
        .snap_mode_i   (snap_mode),
        .snap_irq_i    (snap_irq),
        .snap_ie_i     (snap_ie),
        .snap_o        (snap),
        .commit_o      (commit),
        .commit_hdr_o  (commit_hdr),
        .commit_data_o (commit_data),
        .fail_o        (spi_fail),
        .miso_o        (spi_miso)
    );

    spi_reg_file #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .snap_i        (snap),
        .commit_i      (commit),
        .commit_hdr_i  (commit_hdr),
        .commit_data_i (commit_data),
        .diag_i        (diag_in),
        .irq_i         (irq_in),
        .mode_q_o      (mode_value),
        .ie_q_o        (ie_value),
        .mode_wr_o     (mode_wr),
        .ie_wr_o       (ie_wr),
        .wr_data_o     (wr_data),
        .snap_diag_o   (snap_diag),
        .snap_mode_o   (snap_mode),
        .snap_irq_o    (snap_irq),
        .snap_ie_o     (snap_ie)
    );

    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_wr, ie_wr, spi_fail}));

endmodule

// File: tb/tb_spi_reg_access.sv
module tb_spi_reg_access;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sclk, csn, mosi;
    logic [7:0] diag, irq;
    logic       miso, mode_wr, ie_wr, spi_fail;
    logic [7:0] wr_data, mode_value, ie_value;

    always #4 clk = ~clk;

    spi_reg_access dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_csn    (csn),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .diag_in    (diag),
        .irq_in     (irq),
        .mode_wr    (mode_wr),
        .ie_wr      (ie_wr),
        .wr_data    (wr_data),
        .mode_value (mode_value),
        .ie_value   (ie_value),
        .spi_fail   (spi_fail)
    );

    int checks = 0;
    int errors = 0;
    int n_mode = 0;
    int n_ie = 0;
    int n_fail = 0;
    logic [7:0] last_wr = 8'h00;
    logic [7:0] mode_exp = 8'h80;
    logic [7:0] ie_exp = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mode_wr) n_mode++;
            if (ie_wr) n_ie++;
            if (spi_fail) n_fail++;
            if (mode_wr || ie_wr) last_wr = wr_data;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input int nbits, input logic [15:0] word, input int flip_at,
                        output logic [15:0] rx);
        rx = '0;
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? word[15 - (i % 16)] : 1'b0;
            if (i == flip_at) diag = ~diag;
            repeat (HALF) @(negedge clk);
            if (i < 16) rx[15 - i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_resp(input logic [1:0] bank, input logic rsel);
        logic [7:0] v;
        case ({bank, rsel})
            3'b001:  v = diag;
            3'b000:  v = mode_exp;
            3'b011:  v = irq;
            3'b010:  v = ie_exp;
            default: v = 8'h00;
        endcase
        return {8'h00, v};
    endfunction

    // full 16-bit frame with model update and checks
    task automatic frame16(input logic [1:0] bank, input logic rsel, input logic ro,
                           input logic [11:0] data);
        logic [15:0] rx, exp;
        int m0, i0, f0;
        exp = exp_resp(bank, rsel);
        m0 = n_mode; i0 = n_ie; f0 = n_fail;
        xfer(16, {bank, rsel, ro, data}, -1, rx);
        check("R3", "response word (R9 snapshot)", rx, exp);
        if (!ro && bank == 2'b00) begin
            mode_exp = (data[7:0] & 8'h7F) | 8'h80;
            check("R5", "mode strobe count", n_mode, m0 + 1);
            check("R2", "mode write data", last_wr, mode_exp);
            check("R11", "ie strobe idle", n_ie, i0);
        end else if (!ro && bank == 2'b01) begin
            ie_exp = data[7:0] & 8'h7F;
            check("R5", "ie strobe count", n_ie, i0 + 1);
            check("R2", "ie write data", last_wr, ie_exp);
            check("R11", "mode strobe idle", n_mode, m0);
        end else begin
            check("R4", "no mode strobe", n_mode, m0);
            check("R4", "no ie strobe", n_ie, i0);
        end
        check("R6", "mode register", mode_value, mode_exp);
        check("R6", "ie register", ie_value, ie_exp);
        check("R7", "no failure on full frame", n_fail, f0);
        check("R10", "miso idle", miso, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] rx;
        int m0, i0, f0;
        rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0;
        diag = 8'h3C; irq = 8'hC3;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1", "mode reset", mode_value, 8'h80);
        check("R1", "ie reset", ie_value, 8'h00);
        check("R1", "miso reset", miso, 1'b0);
        check("R1", "no pulses", n_mode + n_ie + n_fail, 0);

        // header sweep over all bank/select/read-only combinations
        for (int pass = 0; pass < 2; pass++) begin
            for (int h = 0; h < 16; h++) begin
                diag = 8'(h * 17 + pass * 5 + 1);
                irq  = ~diag;
                frame16(2'(h >> 2), h[1], h[0], 12'((h * 73 + pass * 151 + 29) & 12'hFFF));
            end
        end

        // R6 reserved bits against extreme write values
        frame16(2'b00, 1'b0, 1'b0, 12'h000);
        frame16(2'b01, 1'b0, 1'b0, 12'hFFF);
        frame16(2'b00, 1'b0, 1'b1, 12'h000);
        frame16(2'b01, 1'b0, 1'b1, 12'h000);

        // R9 input changes after chip select fell
        diag = 8'h5A;
        xfer(16, {2'b00, 1'b1, 1'b1, 12'h000}, 2, rx);
        check("R9", "diag snapshot", rx, 16'h005A);

        // R7/R8 length sweep with failure enable set
        frame16(2'b01, 1'b0, 1'b0, 12'h301);
        for (int n = 0; n <= 20; n++) begin
            if (n == 16) continue;
            m0 = n_mode; i0 = n_ie; f0 = n_fail;
            xfer(n, {2'b00, 1'b0, 1'b0, 12'h0A5}, -1, rx);
            check("R7", "no mode write", n_mode, m0);
            check("R7", "no ie write", n_ie, i0);
            check("R7", "mode value kept", mode_value, mode_exp);
            check("R8", "one failure pulse (R11 width)", n_fail, f0 + 1);
        end

        // failure enable clear: rejected frames are silent
        frame16(2'b01, 1'b0, 1'b0, 12'h0FE);
        for (int n = 0; n <= 20; n++) begin
            if (n == 16) continue;
            m0 = n_mode; f0 = n_fail;
            xfer(n, {2'b01, 1'b0, 1'b0, 12'h0FF}, -1, rx);
            check("R8", "no failure pulse", n_fail, f0);
            check("R7", "ie value kept", ie_value, ie_exp);
            check("R7", "no mode write", n_mode, m0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule